// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus and turns one request into the complete bus protocol for that request. A request carries an operation code, a byte address and a data byte, and it is offered on a valid/ready handshake. Three operations are supported: byte program, sector erase and chip erase. For each one the block emits the unlock and command write cycles. Every write is a strobe on the write-enable pin, with chip-enable held low. Setup, strobe-low and strobe-high durations are each counted in clock cycles.

After the last write the flash runs its internal operation. The block then reads the flash repeatedly with output-enable and watches data bit 7. While the operation is busy, that bit returns the inverse of the expected value. The operation is complete when the bit reads back true: bit 7 of the written byte for a program, and 1 for an erase, since erased bytes read all ones. A cycle budget for each operation type bounds the polling. The outcome is a one-clock done pulse, or a one-clock error pulse when the budget runs out. Only one request is in flight at a time.

Top module: `nor_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, fl_ce_n, fl_we_n and fl_oe_n are 1, fl_dq_oe is 0, and done and error are 0.
- R2: Operation code 0 (byte program) emits exactly four write cycles: 555h/AAh, 2AAh/55h, 555h/A0h, then the request address with the request data.
- R3: Operation code 1 (sector erase) emits exactly six write cycles: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then the request address with 30h.
- R4: Operation code 2 (chip erase) emits the same first five write cycles as R3, then 555h/10h.
- R5: Operation code 3 is accepted, produces no bus activity, and gives an error pulse in the cycle after acceptance.
- R6: In each write cycle, chip enable is low and address and data are driven for T_AS cycles before fl_we_n falls, fl_we_n stays low for T_WP cycles, and address and data stay unchanged for T_WH cycles after it rises.
- R7: Each status read is preceded by T_GAP cycles with fl_ce_n and fl_oe_n both high and the data bus released. The read then holds fl_ce_n and fl_oe_n low for T_RD cycles, and bit 7 of fl_dq_in is sampled in the last of those cycles.
- R8: Polling ends with done when sampled bit 7 equals bit 7 of the request data for a program, or equals 1 for either erase. Otherwise another read follows.
- R9: done or error is high for exactly one cycle, and never both at once.
- R10: With a limit of L cycles for the operation, when a mismatching read ends and L or more cycles have passed since polling began, error is pulsed instead of starting another read.
- R11: req_ready is high only while idle. It falls in the cycle after a request is accepted and returns in the cycle after the done or error pulse.
- R12: fl_we_n is never low while fl_oe_n is low or while fl_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | AW | Byte address or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle successful completion |
| error | output | 1 | One-cycle timeout or invalid operation |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Drive enable for the data bus |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with short phase counts (setup 2, strobe 3, hold 2, gap 2, read 2). With these values every write and read phase can be measured exactly to the cycle. It also uses polling limits of 80 cycles for programs and 400 cycles for erases instead of limits in the seconds range. A stalled program therefore times out after exactly twenty reads, which keeps the error path inside a short run. The bench includes a flash model that stays busy for a chosen number of reads, so polling on both values of bit 7 is exercised.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int UNLK_W = 11;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_BAD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_PGAP,
        ST_PREAD,
        ST_FIN
    } st_e;

    // One write cycle of a command sequence: fixed offset/code or the request's own fields
    typedef struct packed {
        logic              use_tgt_addr;
        logic              use_tgt_data;
        logic [UNLK_W-1:0] ofs;
        logic [7:0]        code;
    } cyc_t;

    function automatic logic [2:0] last_idx(op_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

    function automatic cyc_t cmd_cycle(op_e op, logic [2:0] idx);
        cyc_t c;
        c = '0;
        if (op == OP_PROG && idx == 3'd3) begin
            c.use_tgt_addr = 1'b1;
            c.use_tgt_data = 1'b1;
        end else begin
            case (idx)
                3'd0, 3'd3: begin c.ofs = 11'h555; c.code = 8'hAA; end
                3'd1, 3'd4: begin c.ofs = 11'h2AA; c.code = 8'h55; end
                3'd2: begin
                    c.ofs  = 11'h555;
                    c.code = (op == OP_PROG) ? 8'hA0 : 8'h80;
                end
                3'd5: begin
                    if (op == OP_SECT) begin
                        c.use_tgt_addr = 1'b1;
                        c.code = 8'h30;
                    end else begin
                        c.ofs  = 11'h555;
                        c.code = 8'h10;
                    end
                end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic logic done_bit(op_e op, logic wdata7);
        return (op == OP_PROG) ? wdata7 : 1'b1;
    endfunction

endpackage

// File: rtl/nor_seq_cmd.sv
module nor_seq_cmd
    import nor_seq_pkg::*;
#(
    parameter int AW = 17
) (
    input  op_e             op,
    input  logic [2:0]      idx,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [7:0]      wdata,
    output logic [AW-1:0]   cyc_addr,
    output logic [7:0]      cyc_data,
    output logic            is_last
);
    localparam int PAD = AW - UNLK_W;

    cyc_t cur;

    always_comb begin
        cur      = cmd_cycle(op, idx);
        cyc_addr = cur.use_tgt_addr ? tgt_addr : {{PAD{1'b0}}, cur.ofs};
        cyc_data = cur.use_tgt_data ? wdata : cur.code;
        is_last  = (idx == last_idx(op));
    end
endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
    parameter int TMW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [TMW-1:0] load_val,
    output logic           expired
);
    logic [TMW-1:0] cnt_q;

    // A phase loaded with N lasts N cycles (N >= 1)
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_seq_poll.sv
module nor_seq_poll
    import nor_seq_pkg::*;
#(
    parameter int              TOW     = 33,
    parameter logic [TOW-1:0]  TO_PROG = 33'd50_000,
    parameter logic [TOW-1:0]  TO_SECT = 33'd1_500_000_000,
    parameter logic [TOW-1:0]  TO_CHIP = 33'd6_000_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic active,
    input  op_e  op,
    input  logic wdata7,
    input  logic dq7,
    output logic match,
    output logic out_of_time
);
    logic [TOW-1:0] elapsed_q;
    logic [TOW-1:0] limit;

    always_comb begin
        case (op)
            OP_PROG: limit = TO_PROG;
            OP_SECT: limit = TO_SECT;
            default: limit = TO_CHIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            elapsed_q <= '0;
        else if (active && elapsed_q != '1)
            elapsed_q <= elapsed_q + 1'b1;
    end

    assign match       = (dq7 == done_bit(op, wdata7));
    assign out_of_time = ((elapsed_q + 1'b1) >= limit);
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int              AW      = 17,
    parameter int              TMW     = 8,
    parameter int              T_AS    = 2,
    parameter int              T_WP    = 4,
    parameter int              T_WH    = 3,
    parameter int              T_GAP   = 2,
    parameter int              T_RD    = 8,
    parameter int              TOW     = 33,
    parameter logic [TOW-1:0]  TO_PROG = 33'd50_000,
    parameter logic [TOW-1:0]  TO_SECT = 33'd1_500_000_000,
    parameter logic [TOW-1:0]  TO_CHIP = 33'd6_000_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam logic [TMW-1:0] L_AS  = TMW'(T_AS);
    localparam logic [TMW-1:0] L_WP  = TMW'(T_WP);
    localparam logic [TMW-1:0] L_WH  = TMW'(T_WH);
    localparam logic [TMW-1:0] L_GAP = TMW'(T_GAP);
    localparam logic [TMW-1:0] L_RD  = TMW'(T_RD);

    st_e            st_q, st_d;
    op_e            op_q;
    logic [AW-1:0]  addr_q;
    logic [7:0]     data_q;
    logic [2:0]     idx_q, idx_d;
    logic           fail_q, fail_d;

    logic           tmr_load;
    logic [TMW-1:0] tmr_val;
    logic           tmr_exp;
    logic [AW-1:0]  cyc_addr;
    logic [7:0]     cyc_data;
    logic           cyc_last;
    logic           poll_clear, poll_active, poll_match, poll_late;
    logic           accept;
    logic           in_write;

    nor_seq_cmd #(.AW(AW)) u_cmd (
        .op       (op_q),
        .idx      (idx_q),
        .tgt_addr (addr_q),
        .wdata    (data_q),
        .cyc_addr (cyc_addr),
        .cyc_data (cyc_data),
        .is_last  (cyc_last)
    );

    nor_seq_timer #(.TMW(TMW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    nor_seq_poll #(
        .TOW(TOW), .TO_PROG(TO_PROG), .TO_SECT(TO_SECT), .TO_CHIP(TO_CHIP)
    ) u_poll (
        .clk         (clk),
        .rst         (rst),
        .clear       (poll_clear),
        .active      (poll_active),
        .op          (op_q),
        .wdata7      (data_q[7]),
        .dq7         (fl_dq_in[7]),
        .match       (poll_match),
        .out_of_time (poll_late)
    );

    assign accept      = req_valid && req_ready;
    assign poll_active = (st_q == ST_PGAP) || (st_q == ST_PREAD);
    assign in_write    = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);

    always_comb begin
        st_d       = st_q;
        idx_d      = idx_q;
        fail_d     = fail_q;
        tmr_load   = 1'b0;
        tmr_val    = L_AS;
        poll_clear = 1'b0;
        case (st_q)
            ST_IDLE: begin
                poll_clear = 1'b1;
                idx_d      = '0;
                if (req_valid) begin
                    if (op_e'(req_op) == OP_BAD) begin
                        st_d   = ST_FIN;
                        fail_d = 1'b1;
                    end else begin
                        st_d     = ST_WSETUP;
                        fail_d   = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = L_AS;
                    end
                end
            end
            ST_WSETUP: if (tmr_exp) begin
                st_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = L_WP;
            end
            ST_WPULSE: if (tmr_exp) begin
                st_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = L_WH;
            end
            ST_WHOLD: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (cyc_last) begin
                    st_d       = ST_PGAP;
                    tmr_val    = L_GAP;
                    poll_clear = 1'b1;
                end else begin
                    st_d    = ST_WSETUP;
                    tmr_val = L_AS;
                    idx_d   = idx_q + 3'd1;
                end
            end
            ST_PGAP: if (tmr_exp) begin
                st_d = ST_PREAD; tmr_load = 1'b1; tmr_val = L_RD;
            end
            ST_PREAD: if (tmr_exp) begin
                if (poll_match) begin
                    st_d = ST_FIN; fail_d = 1'b0;
                end else if (poll_late) begin
                    st_d = ST_FIN; fail_d = 1'b1;
                end else begin
                    st_d = ST_PGAP; tmr_load = 1'b1; tmr_val = L_GAP;
                end
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            idx_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            fail_q <= fail_d;
            if (accept) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign done      = (st_q == ST_FIN) && !fail_q;
    assign error     = (st_q == ST_FIN) && fail_q;
    assign fl_ce_n   = !(in_write || st_q == ST_PREAD);
    assign fl_we_n   = (st_q != ST_WPULSE);
    assign fl_oe_n   = (st_q != ST_PREAD);
    assign fl_dq_oe  = in_write;
    assign fl_addr   = in_write ? cyc_addr : addr_q;
    assign fl_dq_out = cyc_data;

    a_r12_we_under_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    a_r12_no_we_oe_overlap: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> fl_oe_n);

    a_r6_stable_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

    a_r7_bus_released_in_read: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (done || error) |=> (!done && !error && req_ready));

    a_r9_not_both: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/nor_seq_ctrl_bench.sv
module nor_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 17;
    localparam int T_AS  = 2;
    localparam int T_WP  = 3;
    localparam int T_WH  = 2;
    localparam int T_GAP = 2;
    localparam int T_RD  = 2;
    localparam int TOW   = 33;
    localparam int LIM_P = 80;
    localparam int LIM_E = 400;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;
    logic          done, error;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // flash model state
    logic [AW-1:0] wr_a [16];
    logic [7:0]    wr_d [16];
    int            wr_cnt = 0;
    logic [AW-1:0] lat_a;
    int            busy_left = 0;
    int            polls_seen = 0;
    logic          exp7 = 1'b1;

    // timing monitor state
    bit mon_en = 0;
    int we_run = 0, su_run = 0, oe_run = 0, gap_run = 0, falls = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_seq_ctrl #(
        .AW(AW), .TMW(8), .T_AS(T_AS), .T_WP(T_WP), .T_WH(T_WH),
        .T_GAP(T_GAP), .T_RD(T_RD), .TOW(TOW),
        .TO_PROG(33'(LIM_P)), .TO_SECT(33'(LIM_E)), .TO_CHIP(33'(LIM_E))
    ) u_nor_seq_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .done(done), .error(error), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    assign fl_dq_in = (!fl_oe_n && !fl_ce_n)
                    ? ((busy_left > 0) ? {~exp7, 7'h2A} : {exp7, 7'h55})
                    : 8'h00;

    always @(negedge fl_we_n) lat_a = fl_addr;
    always @(posedge fl_we_n) begin
        if (mon_en && wr_cnt < 16) begin
            wr_a[wr_cnt] = lat_a;
            wr_d[wr_cnt] = fl_dq_out;
        end
        if (mon_en) wr_cnt++;
    end
    always @(posedge fl_oe_n) begin
        if (mon_en) begin
            polls_seen++;
            if (busy_left > 0) busy_left--;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // bus timing monitor
    always @(negedge clk) begin
        if (mon_en) begin
            if (!fl_we_n) we_run++;
            else if (we_run != 0) begin
                check(we_run == T_WP, "R6 strobe width", we_run, T_WP);
                we_run = 0;
            end
            if (!fl_ce_n && fl_we_n && fl_oe_n && fl_dq_oe) su_run++;
            else if (!fl_we_n && su_run != 0) begin
                check(su_run == ((falls == 0) ? T_AS : T_AS + T_WH), "R6 setup/hold span",
                      su_run, (falls == 0) ? T_AS : T_AS + T_WH);
                falls++;
                su_run = 0;
            end else if (fl_we_n) su_run = 0;
            if (!fl_oe_n) oe_run++;
            else if (oe_run != 0) begin
                check(oe_run == T_RD, "R7 read width", oe_run, T_RD);
                oe_run = 0;
            end
            if (fl_ce_n && fl_oe_n && !fl_dq_oe) gap_run++;
            else if (!fl_oe_n && gap_run != 0) begin
                check(gap_run == T_GAP, "R7 gap before read", gap_run, T_GAP);
                gap_run = 0;
            end else gap_run = 0;
            if (!fl_we_n && (!fl_oe_n || fl_ce_n))
                check(1'b0, "R12 strobe overlap", {fl_ce_n, fl_oe_n}, 2'b01);
        end
    end

    function automatic logic [AW-1:0] exp_a(int op, int i, logic [AW-1:0] a);
        if (i == 0 || i == 2 || i == 3 && op != 0) return 17'h555;
        if (i == 1 || i == 4) return 17'h2AA;
        if (op == 0 && i == 3) return a;
        return (op == 1) ? a : 17'h555;
    endfunction

    function automatic logic [7:0] exp_d(int op, int i, logic [7:0] d);
        case (i)
            0, 3: return (op == 0 && i == 3) ? d : 8'hAA;
            1, 4: return 8'h55;
            2:    return (op == 0) ? 8'hA0 : 8'h80;
            default: return (op == 1) ? 8'h30 : 8'h10;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !error,
              "R1 reset outputs", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, error},
              7'b1111000);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !done && !error,
              "R1 after reset", {req_ready, fl_ce_n, fl_we_n, fl_oe_n}, 4'hF);
        mon_en = 1;
    endtask

    // issue one request; returns outcome and cycles from acceptance to the pulse
    task automatic issue(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input int busy, output bit got_done, output bit got_err,
                         output int lat);
        wr_cnt = 0; polls_seen = 0; falls = 0; busy_left = busy;
        exp7 = (op == 0) ? d[7] : 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d;
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 0; got_err = 0; lat = 1;
        while (!done && !error && lat < 5000) begin
            check(!req_ready, "R11 ready low while busy", req_ready, 0);
            @(negedge clk);
            lat++;
        end
        got_done = done; got_err = error;
        @(negedge clk);
        check(req_ready && !done && !error, "R9/R11 single pulse then ready",
              {req_ready, done, error}, 3'b100);
    endtask

    task automatic check_seq(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                             input string tag);
        int n = (op == 0) ? 4 : 6;
        check(wr_cnt == n, {tag, " write count"}, wr_cnt, n);
        for (int i = 0; i < n && i < wr_cnt; i++) begin
            check(wr_a[i] == exp_a(op, i, a), {tag, " address"}, wr_a[i], exp_a(op, i, a));
            check(wr_d[i] == exp_d(op, i, d), {tag, " data"}, wr_d[i], exp_d(op, i, d));
        end
    endtask

    task automatic t_program_low_bit();
        bit dn, er; int lat;
        issue(0, 17'h1_2345, 8'h5A, 3, dn, er, lat);
        check_seq(0, 17'h1_2345, 8'h5A, "R2");
        check(dn && !er, "R8 program bit7=0 done", {dn, er}, 2'b10);
        check(polls_seen == 4, "R8 polls until match", polls_seen, 4);
    endtask

    task automatic t_program_high_bit();
        bit dn, er; int lat;
        issue(0, 17'h0_0ABC, 8'hC3, 1, dn, er, lat);
        check_seq(0, 17'h0_0ABC, 8'hC3, "R2");
        check(dn && !er, "R8 program bit7=1 done", {dn, er}, 2'b10);
        check(polls_seen == 2, "R8 polls until match", polls_seen, 2);
    endtask

    task automatic t_sector_erase();
        bit dn, er; int lat;
        issue(1, 17'h1_8000, 8'h00, 5, dn, er, lat);
        check_seq(1, 17'h1_8000, 8'h00, "R3");
        check(dn && !er, "R8 sector erase done on 1", {dn, er}, 2'b10);
        check(polls_seen == 6, "R8 erase polls", polls_seen, 6);
    endtask

    task automatic t_chip_erase();
        bit dn, er; int lat;
        issue(2, 17'h0_4444, 8'h00, 2, dn, er, lat);
        check_seq(2, 17'h0_4444, 8'h00, "R4");
        check(dn && !er, "R8 chip erase done", {dn, er}, 2'b10);
    endtask

    task automatic t_timeout();
        bit dn, er; int lat;
        issue(0, 17'h0_0010, 8'h80, 1000, dn, er, lat);
        check(er && !dn, "R10 timeout gives error", {dn, er}, 2'b01);
        check(polls_seen == LIM_P / (T_GAP + T_RD), "R10 reads before timeout",
              polls_seen, LIM_P / (T_GAP + T_RD));
        busy_left = 0;
    endtask

    task automatic t_bad_op();
        bit dn, er; int lat;
        issue(3, 17'h0_0001, 8'h11, 0, dn, er, lat);
        check(er && !dn, "R5 invalid op error", {dn, er}, 2'b01);
        check(lat == 1, "R5 error next cycle", lat, 1);
        check(wr_cnt == 0 && polls_seen == 0, "R5 no bus activity", wr_cnt + polls_seen, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        t_program_low_bit();
        t_program_high_bit();
        t_sector_erase();
        t_chip_erase();
        t_bad_op();
        t_timeout();
        t_program_low_bit();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule